// File: doc/BRIEF.md
# Configurable UART Transmit Serializer

This block turns bytes offered on a one-cycle write strobe into asynchronous serial characters on one output line. Each byte first lands in a one-entry holding stage. While no character is on the line, the byte moves from there into a shifting sequencer. The sequencer sends a low start bit, then 5 to 8 data bits with the least significant bit first. An optional parity bit comes next, and the character ends with a high stop period of one, one and a half or two bit times. The line rests high between characters.

Bit timing comes from an enable pulse that an external divider supplies at sixteen times the bit rate. Each bit lasts sixteen of those pulses. A set of static format inputs chooses the word length, the parity behaviour and the stop length. A separate break input pulls the line low whenever it is set. The host watches two flags: one says the holding stage can take another byte, and the other says that the holding stage is empty and no character is being sent. A write that arrives while the holding stage is occupied is dropped, and the block reports it with a one-cycle pulse.

Top module: `uart_tx_serializer`

## Requirements
- R1: After synchronous reset, txd is 1, hold_empty is 1, all_empty is 1 and wr_overflow is 0. Whenever no character is in progress and cfg_break is 0, txd is 1.
- R2: A character begins in the cycle after the edge that moves the byte into the sequencer. It begins with txd at 0. The start bit, every data bit and the parity bit each last exactly 16 tick pulses. Without break, txd changes only at an edge where tick was 1, or at the start of a character.
- R3: cfg_wlen selects the data bit count: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data is sent with bit 0 first. Byte bits above the selected count are never sent.
- R4: With cfg_par_en=1 and cfg_par_stick=0, a parity bit follows the last data bit. With cfg_par_even=1 it makes the count of ones over the sent data bits and parity bit even; with cfg_par_even=0 it makes that count odd. With cfg_par_en=0 no parity bit is sent.
- R5: With cfg_par_en=1 and cfg_par_stick=1, the parity bit is the constant NOT cfg_par_even, whatever the data.
- R6: The stop period holds txd at 1. With cfg_stop_long=0 it lasts 16 ticks. With cfg_stop_long=1 it lasts 24 ticks when cfg_wlen is 0 and 32 ticks otherwise.
- R7: A write into an empty holding stage is taken at that edge, and hold_empty reads 0 in the following cycle. The byte moves into the sequencer at the first edge at which the holding stage is full and no character is in progress. hold_empty returns to 1 after that edge. Back-to-back characters therefore begin the cycle after the previous stop period ends.
- R8: A write made while the holding stage is full is ignored: the held byte stays unchanged and is the next one sent. wr_overflow is 1 for exactly the cycle after each such write.
- R9: cfg_break=1 drives txd to 0 in the same cycle, both during a character and between characters. It does not alter the timing or content of the character in progress.
- R10: hold_empty is 1 exactly when the holding stage is empty. all_empty is 1 exactly when the holding stage is empty and no character is in progress, including its stop period.
- R11: The word length, parity and stop settings are captured when a byte enters the sequencer. Changing them during a character affects only later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | DW (8) | Byte to send |
| cfg_wlen | input | 2 | Word length code: 0..3 gives 5..8 data bits |
| cfg_stop_long | input | 1 | 0: one stop bit; 1: 1.5 stop bits (5-bit words) or 2 stop bits |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_even | input | 1 | Even parity select; its inverse is the sticky value |
| cfg_par_stick | input | 1 | Sends a constant parity bit |
| cfg_break | input | 1 | Holds txd low while set |
| txd | output | 1 | Serial output line, idle high |
| hold_empty | output | 1 | Holding stage can accept a byte |
| all_empty | output | 1 | Holding stage empty and line idle |
| wr_overflow | output | 1 | One-cycle pulse after a dropped write |

## Verification
Corrupted sequencer state shows up on txd. A wrong tick count moves the next bit edge by at least one tick. A wrong bit index or shift adds or drops a data bit, so every later bit of that character is misplaced. A wrong latched format shows up as a parity or stop-length error within one character. Errors in the holding stage show up at the status pins: hold_empty and all_empty would disagree with the expected values on the first clock after the faulty transfer. A corrupted held byte would appear in the next character sent. Because the bench compares all four outputs with an independent model on every clock, each of these faults is reported within a cycle of first reaching a port.

// File: rtl/uart_txs_pkg.sv
package uart_txs_pkg;

    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_DATA  = 2'd1,
        PH_PAR   = 2'd2,
        PH_STOP  = 2'd3
    } txs_phase_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       stop_long;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } txs_fmt_t;

    localparam int MIN_BITS = 5;

    // number of data bits for a word length code
    function automatic logic [3:0] fmt_bits(input logic [1:0] wlen);
        return 4'(MIN_BITS) + {2'b00, wlen};
    endfunction

    // mask of the byte bits that are actually sent
    function automatic logic [7:0] fmt_mask(input logic [1:0] wlen);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < 8; i++) begin
            m[i] = (i < int'(fmt_bits(wlen)));
        end
        return m;
    endfunction

    // parity bit value for a byte under a given format
    function automatic logic fmt_parity(input logic [7:0] d, input txs_fmt_t f);
        logic x;
        x = ^(d & fmt_mask(f.wlen));
        if (f.par_stick) begin
            return ~f.par_even;
        end
        return f.par_even ? x : ~x;
    endfunction

endpackage

// File: rtl/uart_txs_hold.sv
module uart_txs_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          overflow
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full     <= 1'b0;
            data     <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= wr_en & full;
            if (wr_en && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(data));

endmodule

// File: rtl/uart_txs_shift.sv
module uart_txs_shift
    import uart_txs_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  txs_fmt_t      load_fmt,
    output logic          busy,
    output logic          line
);

    localparam int CW = $clog2(2 * OSR + 1);
    localparam int BW = $clog2(DW);

    logic          busy_q;
    txs_phase_e    ph_q;
    logic [CW-1:0] tcnt_q;
    logic [BW-1:0] bidx_q;
    logic [DW-1:0] sh_q;
    txs_fmt_t      fmt_q;
    logic          par_q;

    logic [CW-1:0] len;
    logic          bit_done;
    logic          last_data;

    // length of the current element in ticks
    always_comb begin
        if (ph_q == PH_STOP) begin
            if (!fmt_q.stop_long) begin
                len = CW'(OSR);
            end else if (fmt_q.wlen == 2'b00) begin
                len = CW'(OSR + OSR / 2);
            end else begin
                len = CW'(2 * OSR);
            end
        end else begin
            len = CW'(OSR);
        end
    end

    assign bit_done  = busy_q && tick && (tcnt_q == len - 1'b1);
    assign last_data = (int'(bidx_q) == int'(fmt_bits(fmt_q.wlen)) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ph_q   <= PH_START;
            tcnt_q <= '0;
            bidx_q <= '0;
            sh_q   <= '0;
            fmt_q  <= '0;
            par_q  <= 1'b0;
        end else if (!busy_q) begin
            if (load) begin
                busy_q <= 1'b1;
                ph_q   <= PH_START;
                tcnt_q <= '0;
                bidx_q <= '0;
                sh_q   <= load_data;
                fmt_q  <= load_fmt;
                par_q  <= fmt_parity(8'(load_data), load_fmt);
            end
        end else if (tick) begin
            if (!bit_done) begin
                tcnt_q <= tcnt_q + 1'b1;
            end else begin
                tcnt_q <= '0;
                unique case (ph_q)
                    PH_START: ph_q <= PH_DATA;
                    PH_DATA: begin
                        if (last_data) begin
                            ph_q <= fmt_q.par_en ? PH_PAR : PH_STOP;
                        end else begin
                            sh_q   <= sh_q >> 1;
                            bidx_q <= bidx_q + 1'b1;
                        end
                    end
                    PH_PAR:  ph_q   <= PH_STOP;
                    PH_STOP: busy_q <= 1'b0;
                endcase
            end
        end
    end

    always_comb begin
        unique case (ph_q)
            PH_START: line = 1'b0;
            PH_DATA:  line = sh_q[0];
            PH_PAR:   line = par_q;
            PH_STOP:  line = 1'b1;
        endcase
    end

    assign busy = busy_q;

    // R2
    tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (tcnt_q < len));

    // R2
    line_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$past(tick)) |-> $stable(line));

    // R6
    stop_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(ph_q) == PH_STOP && $past(tick)));

    // R3
    data_count_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && ph_q == PH_DATA) |-> (int'(bidx_q) < int'(fmt_bits(fmt_q.wlen))));

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
    import uart_txs_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    cfg_wlen,
    input  logic          cfg_stop_long,
    input  logic          cfg_par_en,
    input  logic          cfg_par_even,
    input  logic          cfg_par_stick,
    input  logic          cfg_break,
    output logic          txd,
    output logic          hold_empty,
    output logic          all_empty,
    output logic          wr_overflow
);

    txs_fmt_t      fmt;
    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          take;
    logic          sh_busy;
    logic          sh_line;

    assign fmt = '{wlen: cfg_wlen, stop_long: cfg_stop_long, par_en: cfg_par_en,
                   par_even: cfg_par_even, par_stick: cfg_par_stick};

    assign take = hold_full & ~sh_busy;

    uart_txs_hold #(.DW(DW)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data),
        .overflow (wr_overflow)
    );

    uart_txs_shift #(.DW(DW), .OSR(OSR)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load      (take),
        .load_data (hold_data),
        .load_fmt  (fmt),
        .busy      (sh_busy),
        .line      (sh_line)
    );

    assign txd        = ~cfg_break & (sh_busy ? sh_line : 1'b1);
    assign hold_empty = ~hold_full;
    assign all_empty  = ~hold_full & ~sh_busy;

    // R7
    hand_off_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !sh_busy) |=> (sh_busy && !hold_full));

    // R10
    idle_return_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(all_empty) |-> $fell(sh_busy));

endmodule

// File: tb/sim_uart_tx_serializer.sv
module sim_uart_tx_serializer;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_stop_long = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       cfg_break = 1'b0;
    logic       txd, hold_empty, all_empty, wr_overflow;

    uart_tx_serializer u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_wlen(cfg_wlen), .cfg_stop_long(cfg_stop_long), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick), .cfg_break(cfg_break),
        .txd(txd), .hold_empty(hold_empty), .all_empty(all_empty), .wr_overflow(wr_overflow)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    int    tdiv = 3;
    int    tcnt = 0;
    string req = "R1";
    bit    done = 1'b0;

    // reference model: queue of (level, length in ticks) per line element
    int         qv[$];
    int         ql[$];
    int         m_rem = 0;
    bit         m_full = 1'b0;
    bit         m_ovf = 1'b0;
    logic [7:0] m_data = 8'h00;

    function automatic void build(input logic [7:0] d);
        int nb;
        int ones;
        int p;
        nb = 5 + int'(cfg_wlen);
        ones = 0;
        qv.push_back(0); ql.push_back(16);
        for (int i = 0; i < nb; i++) begin
            qv.push_back(int'(d[i])); ql.push_back(16);
            ones += int'(d[i]);
        end
        if (cfg_par_en) begin
            if (cfg_par_stick) p = cfg_par_even ? 0 : 1;
            else if (cfg_par_even) p = ones % 2;
            else p = 1 - (ones % 2);
            qv.push_back(p); ql.push_back(16);
        end
        qv.push_back(1);
        ql.push_back(!cfg_stop_long ? 16 : (nb == 5 ? 24 : 32));
    endfunction

    always @(posedge clk) begin
        bit pf;
        bit pi;
        if (rst) begin
            qv.delete(); ql.delete();
            m_full = 1'b0; m_ovf = 1'b0; m_rem = 0;
        end else begin
            pf = m_full;
            pi = (qv.size() == 0);
            if (!pi && tick) begin
                m_rem--;
                if (m_rem == 0) begin
                    void'(qv.pop_front());
                    void'(ql.pop_front());
                    if (ql.size() > 0) m_rem = ql[0];
                end
            end
            if (pf && pi) begin
                build(m_data);
                m_rem = ql[0];
                m_full = 1'b0;
            end
            m_ovf = wr_en && pf;
            if (wr_en && !pf) begin
                m_full = 1'b1;
                m_data = wr_data;
            end
        end
    end

    task automatic chk1(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %b expected %b cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // compare every output with the model away from the active edge
    always @(negedge clk) begin
        logic e_txd;
        if (!rst && !done) begin
            e_txd = cfg_break ? 1'b0 : ((qv.size() > 0) ? qv[0][0] : 1'b1);
            chk1(txd, e_txd, "txd");
            chk1(hold_empty, !m_full, "hold_empty");
            chk1(all_empty, !m_full && (qv.size() == 0), "all_empty");
            chk1(wr_overflow, m_ovf, "wr_overflow");
        end
    end

    // tick pulse source
    always @(posedge clk) begin
        #1;
        if (tcnt >= tdiv - 1) begin
            tcnt = 0; tick = 1'b1;
        end else begin
            tcnt++; tick = 1'b0;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL %s watchdog actual %0d expected below %0d", req, cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // all tasks enter and leave one time unit after a rising edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        while (m_full) step(1);
        wr(d);
    endtask

    task automatic wait_idle();
        while (m_full || qv.size() != 0) step(1);
        step(2);
    endtask

    task automatic set_fmt(input logic [1:0] wl, input logic sl, input logic pe,
                           input logic ev, input logic st);
        cfg_wlen = wl; cfg_stop_long = sl; cfg_par_en = pe;
        cfg_par_even = ev; cfg_par_stick = st;
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        // R1: reset values at the ports
        @(negedge clk);
        req = "R1";
        chk1(txd, 1'b1, "reset txd");
        chk1(hold_empty, 1'b1, "reset hold_empty");
        chk1(all_empty, 1'b1, "reset all_empty");
        chk1(wr_overflow, 1'b0, "reset wr_overflow");
        step(5);

        // R2: basic 8-bit frames
        req = "R2";
        set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hA5);
        // R7 and R10: second byte queued behind the first, back to back
        req = "R7";
        send(8'h3C);
        req = "R10";
        send(8'h81);
        wait_idle();

        // R3: shorter word lengths drop the upper bits
        req = "R3";
        for (int w = 0; w < 3; w++) begin
            cfg_wlen = 2'(w);
            send(8'hFF);
            send(8'hE3);
            wait_idle();
        end

        // R4: even and odd parity
        req = "R4";
        set_fmt(2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
        send(8'h07); send(8'h03);
        wait_idle();
        cfg_par_even = 1'b0;
        send(8'h07); send(8'h03);
        wait_idle();
        set_fmt(2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        send(8'hF5);
        wait_idle();

        // R5: sticky parity
        req = "R5";
        set_fmt(2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
        send(8'h00); send(8'hFF);
        wait_idle();
        cfg_par_even = 1'b1;
        send(8'h00); send(8'hFF);
        wait_idle();

        // R6: long stop periods
        req = "R6";
        set_fmt(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h15); send(8'h0A);
        wait_idle();
        cfg_wlen = 2'd3;
        send(8'h6A);
        wait_idle();
        cfg_wlen = 2'd1;
        send(8'h2D);
        wait_idle();
        cfg_stop_long = 1'b0;

        // R8: writes into a full holding stage are dropped
        req = "R8";
        set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        wr(8'h11);
        wr(8'h22);
        wr(8'h33);
        wr(8'h44);
        wr(8'h55);
        wait_idle();

        // R9: break during a character and while idle
        req = "R9";
        send(8'h5A);
        step(100);
        cfg_break = 1'b1;
        step(200);
        cfg_break = 1'b0;
        wait_idle();
        cfg_break = 1'b1;
        step(20);
        cfg_break = 1'b0;
        step(5);

        // R11: format changes during a character apply to the next one
        req = "R11";
        send(8'hC3);
        send(8'h96);
        step(10);
        set_fmt(2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        wait_idle();
        set_fmt(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);

        // R2: tick on every clock
        req = "R2";
        tdiv = 1;
        send(8'h4E); send(8'hB1);
        wait_idle();
        tdiv = 2;
        cfg_par_en = 1'b1;
        send(8'h9C);
        wait_idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule